// File: doc/BRIEF.md
# Iterative AES-128 Encryption Core

This block encrypts a single 128-bit block under a 128-bit key with the AES-128 cipher. It reuses one round datapath for the whole cipher and completes one round per clock. A caller presents the key and plaintext with a one-cycle start strobe. The ciphertext then appears on the output, and a one-cycle done pulse marks it as valid.

On an accepted start, the core loads the state with the plaintext XORed with the raw key. A companion key-schedule unit then derives each round key on the fly, one key per cycle. The next ten clock edges each apply one round. Rounds one to nine include the column mixing step. Round ten skips it, and this choice is made by the round counter. While a block is in flight, further start strobes are ignored. The final ciphertext stays on the output until the next accepted start.

Top module: `aes128_iter_enc`

## Requirements
- R1: After reset, `ct_o` is all zeros and `done_o` is low.
- R2: Byte k of a 128-bit bus sits at bits [127-8k : 120-8k]. In the state matrix, byte k is row k mod 4 of column k div 4. Plaintext, key and ciphertext all use this order.
- R3: The core first XORs the plaintext with the key. It then runs nine rounds of substitute, row rotate, column mix and key add, and a tenth round without the column mix. The result matches the AES-128 known answers: key 000102..0F with plaintext 00112233..EEFF gives 69C4E0D86A7B0430D8CDB78070B4C55A, and key 2B7E151628AED2A6ABF7158809CF4F3C with plaintext 3243F6A8885A308D313198A2E0370734 gives 3925841D02DC09FBDC118597196A0B32.
- R4: The byte substitution is the multiplicative inverse in GF(2^8) modulo 0x11B, with 0 mapped to 0, followed by the affine map with constant 0x63. A zero key with a zero plaintext gives 66E94BD4EF8A2C3B884CFA59CA342B2E.
- R5: Rows 1, 2 and 3 rotate left by 1, 2 and 3 bytes. Row 0 is not rotated. Column mixing uses the matrix rows [2 3 1 1], [1 2 3 1], [1 1 2 3] and [3 1 1 2]. Doubling is a left shift, XORed with 0x1B when the top bit was set.
- R6: Round key r is derived from key r-1 with round constants 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36 for rounds 1 to 10.
- R7: If `start_i` is sampled high in cycle k while idle, `done_o` is high in cycle k+11 and only in that cycle.
- R8: A `start_i` strobe that arrives while a block is being processed has no effect on the result or on the done timing.
- R9: After done, `ct_o` holds the ciphertext unchanged, whatever the inputs do, until the next accepted start.
- R10: A start in the same cycle as `done_o` is accepted and produces its own result 11 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe; captures key and plaintext when idle |
| key_i | input | 128 | Cipher key |
| pt_i | input | 128 | Plaintext block |
| ct_o | output | 128 | Ciphertext (final state) |
| done_o | output | 1 | One-cycle pulse when ct_o holds the result |

## Verification
Inputs are driven on the falling edge, and the start strobe is high for one cycle, k. The bench then counts falling edges and expects `done_o` at the eleventh edge, then low again at the twelfth. The ciphertext is compared in the cycle of the pulse. For the ignored-strobe case, the bench sends a second start three cycles into a block and checks that the done pulse still lands on cycle k+11 with the first result. It then watches a further window for a stray pulse. For the hold and back-to-back cases, the bench samples `ct_o` over twenty idle cycles. It also chains a start onto the done cycle and expects a second pulse exactly eleven cycles after it.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;

  localparam int BLK_BITS = 128;
  localparam int WORD_BITS = 32;
  localparam int BLK_BYTES = BLK_BITS / 8;

  typedef logic [BLK_BITS-1:0] blk_t;
  typedef logic [WORD_BITS-1:0] word_t;

  // doubling in GF(2^8), reduction polynomial 0x11B
  function automatic logic [7:0] gf_dbl(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_tpl(input logic [7:0] b);
    return gf_dbl(b) ^ b;
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    return acc;
  endfunction

  // inverse as x^254; zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] pw;
    logic [7:0] prod;
    pw = x;
    prod = 8'h01;
    for (int i = 1; i < 8; i++) begin
      pw = gf_mul(pw, pw);
      prod = gf_mul(prod, pw);
    end
    return prod;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] v;
    v = gf_inv(x);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] get_byte(input blk_t s, input int k);
    return s[BLK_BITS-1-8*k -: 8];
  endfunction

  function automatic word_t sub_word(input word_t w);
    return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
  endfunction

  function automatic word_t mix_word(input word_t w);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = w;
    return {gf_dbl(a0) ^ gf_tpl(a1) ^ a2 ^ a3,
            a0 ^ gf_dbl(a1) ^ gf_tpl(a2) ^ a3,
            a0 ^ a1 ^ gf_dbl(a2) ^ gf_tpl(a3),
            gf_tpl(a0) ^ a1 ^ a2 ^ gf_dbl(a3)};
  endfunction

  // row r of column c takes byte from column (c+r) mod 4
  function automatic blk_t rot_rows(input blk_t s);
    blk_t o;
    o = '0;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[BLK_BITS-1-8*(4*c+r) -: 8] = get_byte(s, 4*((c + r) % 4) + r);
    return o;
  endfunction

endpackage

// File: rtl/aes_key_step.sv
module aes_key_step
  import aes_enc_pkg::*;
#(
  parameter int KEY_BITS = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                step_i,
  input  logic [KEY_BITS-1:0] key_i,
  output logic [KEY_BITS-1:0] rk_o
);
  localparam int NWORDS = KEY_BITS / WORD_BITS;

  logic [KEY_BITS-1:0] kq;
  logic [7:0]          rcon_q;
  word_t               w_cur [NWORDS];
  word_t               w_nxt [NWORDS];
  word_t               mixin;

  generate
    for (genvar i = 0; i < NWORDS; i++) begin : g_split
      assign w_cur[i] = kq[KEY_BITS-1-WORD_BITS*i -: WORD_BITS];
    end
  endgenerate

  assign mixin = sub_word({w_cur[NWORDS-1][23:0], w_cur[NWORDS-1][31:24]})
                 ^ {rcon_q, 24'h0};

  generate
    for (genvar i = 0; i < NWORDS; i++) begin : g_chain
      if (i == 0) begin : g_first
        assign w_nxt[i] = w_cur[i] ^ mixin;
      end else begin : g_rest
        assign w_nxt[i] = w_cur[i] ^ w_nxt[i-1];
      end
      assign rk_o[KEY_BITS-1-WORD_BITS*i -: WORD_BITS] = w_nxt[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kq     <= '0;
      rcon_q <= 8'h01;
    end else if (load_i) begin
      kq     <= key_i;
      rcon_q <= 8'h01;
    end else if (step_i) begin
      kq     <= rk_o;
      rcon_q <= gf_dbl(rcon_q);
    end
  end

  AST_RCON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> rcon_q == 8'h01); // R6
  AST_KEY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> kq == $past(key_i)); // R6

endmodule

// File: rtl/aes_round_dp.sv
module aes_round_dp
  import aes_enc_pkg::*;
(
  input  blk_t state_i,
  input  blk_t rk_i,
  input  logic skip_mix_i,
  output blk_t state_o
);
  blk_t subbed;
  blk_t shifted;
  blk_t mixed;

  generate
    for (genvar k = 0; k < BLK_BYTES; k++) begin : g_sub
      assign subbed[BLK_BITS-1-8*k -: 8] = sbox(state_i[BLK_BITS-1-8*k -: 8]);
    end
  endgenerate

  assign shifted = rot_rows(subbed);

  generate
    for (genvar c = 0; c < 4; c++) begin : g_mix
      assign mixed[BLK_BITS-1-WORD_BITS*c -: WORD_BITS] =
        mix_word(shifted[BLK_BITS-1-WORD_BITS*c -: WORD_BITS]);
    end
  endgenerate

  assign state_o = (skip_mix_i ? shifted : mixed) ^ rk_i;

endmodule

// File: rtl/aes128_iter_enc.sv
module aes128_iter_enc
  import aes_enc_pkg::*;
#(
  parameter int KEY_BITS = 128
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [127:0]   key_i,
  input  logic [127:0]   pt_i,
  output logic [127:0]   ct_o,
  output logic           done_o
);
  localparam int NROUNDS = KEY_BITS / WORD_BITS + 6;
  localparam int CW = $clog2(NROUNDS + 1);

  blk_t          state_q;
  blk_t          round_out;
  blk_t          rk;
  logic [CW-1:0] rnd_q;
  logic          busy_q;
  logic          done_q;

  // named events for the assertions
  wire accept     = start_i && !busy_q;
  wire last_round = busy_q && (rnd_q == CW'(NROUNDS));

  aes_key_step #(.KEY_BITS(KEY_BITS)) u_keys (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .step_i (busy_q),
    .key_i  (key_i),
    .rk_o   (rk)
  );

  aes_round_dp u_round (
    .state_i    (state_q),
    .rk_i       (rk),
    .skip_mix_i (last_round),
    .state_o    (round_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      rnd_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= pt_i ^ key_i;
        rnd_q   <= CW'(1);
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        state_q <= round_out;
        if (last_round) begin
          busy_q <= 1'b0;
          rnd_q  <= '0;
          done_q <= 1'b1;
        end else begin
          rnd_q <= rnd_q + CW'(1);
        end
      end
    end
  end

  assign ct_o   = state_q;
  assign done_o = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_round |=> done_o && !busy_q); // R7
  AST_STRAY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_round) |=> rnd_q == $past(rnd_q) + CW'(1)); // R8
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_q && rnd_q == CW'(1)); // R10
  AST_CT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start_i) |=> $stable(ct_o)); // R9

endmodule

// File: tb/test_aes128_iter_enc.sv
module test_aes128_iter_enc;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] key_i = '0;
  logic [127:0] pt_i = '0;
  logic [127:0] ct_o;
  logic         done_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  localparam logic [127:0] K1 = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] P1 = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] C1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] K2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] P2 = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] C2 = 128'h3925841d02dc09fbdc118597196a0b32;
  localparam logic [127:0] C0 = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;

  always #5 clk = ~clk;

  aes128_iter_enc i_aes128_iter_enc (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .key_i(key_i), .pt_i(pt_i), .ct_o(ct_o), .done_o(done_o)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive start in the current cycle, return the cycle offset of the first done
  task automatic launch(input logic [127:0] k, input logic [127:0] p, output int when);
    start_i = 1'b1; key_i = k; pt_i = p;
    @(negedge clk);
    start_i = 1'b0;
    when = 0;
    for (int i = 1; i <= 12; i++) begin
      if (i > 1) @(negedge clk);
      if (done_o && when == 0) when = i;
      if (when != 0) break;
    end
  endtask

  task automatic t_reset;
    check("R1 ct", ct_o, '0);
    check("R1 done", {127'b0, done_o}, '0);
  endtask

  task automatic t_vector(input string req, input logic [127:0] k,
                          input logic [127:0] p, input logic [127:0] exp);
    int when;
    launch(k, p, when);
    check({req, " done cycle R7"}, 128'(when), 128'd11);
    check(req, ct_o, exp);
    @(negedge clk);
    check("R7 pulse width", {127'b0, done_o}, '0);
  endtask

  task automatic t_busy_start;
    int when;
    int stray;
    start_i = 1'b1; key_i = K1; pt_i = P1;
    @(negedge clk);
    start_i = 1'b0;
    when = 0;
    for (int i = 1; i <= 12; i++) begin
      if (i > 1) @(negedge clk);
      if (i == 3) begin start_i = 1'b1; key_i = K2; pt_i = P2; end
      if (i == 4) start_i = 1'b0;
      if (done_o && when == 0) when = i;
      if (when != 0) break;
    end
    check("R8 done cycle", 128'(when), 128'd11);
    check("R8 result", ct_o, C1);
    stray = 0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (done_o) stray++;
    end
    check("R8 no second done", 128'(stray), 128'd0);
  endtask

  task automatic t_hold;
    int bad;
    bad = 0;
    key_i = K2; pt_i = P2;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      key_i = ~key_i; pt_i = pt_i + 1;
      if (ct_o !== C1) bad++;
    end
    check("R9 held cycles mismatched", 128'(bad), 128'd0);
  endtask

  task automatic t_back_to_back;
    int when;
    launch(K2, P2, when);
    check("R10 first done", 128'(when), 128'd11);
    check("R10 first result", ct_o, C2);
    // chain in the done cycle
    launch(K1, P1, when);
    check("R10 chained done", 128'(when), 128'd11);
    check("R10 chained result", ct_o, C1);
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_vector("R3 R2 vector1", K1, P1, C1);
    t_vector("R3 R6 vector2", K2, P2, C2);
    t_vector("R4 R5 zero vector", '0, '0, C0);
    t_busy_start();
    t_hold();
    t_back_to_back();
    finish_run();
  end

endmodule